// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Accounting

This block collects the event pulses of one DMA channel's datapath and turns them into a single level interrupt. It keeps a 12-bit raw status word and a 12-bit mask. Software clears status bits by writing ones to them. Software never writes the mask directly; it clears mask bits through an enable register and sets them through a disable register. Two 8-bit counters record how many source and destination descriptors finished. Each counter returns its value and clears itself when software reads it. When a counter wraps, a dedicated accounting-error status bit is raised.

The register port is a simple single-cycle access. `regEn` qualifies the access and `regWe` selects a write. `regAddr` is a word index. Read data is combinational and valid in the access cycle. Every side effect of an access takes hold at the clock edge that ends that cycle. The status, mask and counter values seen at the ports are the registered state after that edge. The interrupt output is formed combinationally from that registered state.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Each event input sets its own status bit at the next clock edge. The bit positions are: source descriptor done 1, destination descriptor done 2, byte count overflow 3, source descriptor read error 6, destination descriptor read error 7, data read error 8, data write error 9, DMA done 10, pause 11. Status bits 0, 4 and 5 are raised only by the block itself.
- R2: A write to word 0x0 clears every status bit written as one and leaves the bits written as zero. A read of word 0x0 returns the status in bits 11:0, with bits 31:12 reading zero. The status register resets to zero.
- R3: The mask reads at word 0x1 and resets to 0xFFF. A write to word 0x1 leaves the mask unchanged.
- R4: A write to word 0x2 clears the mask bits written as one. A write to word 0x3 sets the mask bits written as one. Both words read as zero.
- R5: `irqOut` is high exactly when some status bit is set while its mask bit is clear. It follows the registered state with no further delay.
- R6: A source descriptor done event increments the source counter, which reads at word 0x4. When that increment takes the counter from 255 to 0, status bit 4 is also set. The destination counter reads at word 0x5 and behaves the same way, setting status bit 5.
- R7: A read of a counter returns its current value and clears it to zero at the same edge. A write to a counter word is ignored.
- R8: An access with `regEn` high to any word above 0x5 sets status bit 0. A read of such a word returns zero, and a write to it changes no other state.
- R9: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends set.
- R10: Several events in one cycle are all recorded. If a counter is read in the same cycle as its increment, the read returns the old value, the counter becomes 1, and no accounting error is raised.
- R11: `regRdata` is zero whenever `regEn` is low or `regWe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regEn | input | 1 | Register access in this cycle |
| regWe | input | 1 | Access is a write |
| regAddr | input | 4 | Word index of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| evSrcDscrDone | input | 1 | Source descriptor completed (pulse) |
| evDstDscrDone | input | 1 | Destination descriptor completed (pulse) |
| evByteCntOvf | input | 1 | Byte count overflow (pulse) |
| evSrcDscrRdErr | input | 1 | Source descriptor fetch error (pulse) |
| evDstDscrRdErr | input | 1 | Destination descriptor fetch error (pulse) |
| evDataRdErr | input | 1 | Data read bus error (pulse) |
| evDataWrErr | input | 1 | Data write bus error (pulse) |
| evDmaDone | input | 1 | Transfer finished (pulse) |
| evDmaPause | input | 1 | Channel paused (pulse) |
| irqOut | output | 1 | Level interrupt |

## Verification
The assertions assume that every event input is a one-cycle pulse sampled at the clock edge. They also assume the register port carries at most one access per cycle, and that any input, including the address, may change freely between edges. The stimulus drives all inputs just after the falling edge. It draws events, addresses and write data from a fixed-seed random source, so that several events may coincide with each other and with register clears. The address range reaches beyond the mapped words, so invalid accesses are exercised along with the valid ones. Directed runs force the counter wrap, a counter read in the same cycle as its increment, and a clear that collides with a set.

// File: rtl/dmaIrqPkg.sv
package dmaIrqPkg;
  localparam int NUM_SRC = 12;

  // status bit positions
  localparam int B_BAD_ACC   = 0;
  localparam int B_SRC_DONE  = 1;
  localparam int B_DST_DONE  = 2;
  localparam int B_BYTE_OVF  = 3;
  localparam int B_SRC_ACCT  = 4;
  localparam int B_DST_ACCT  = 5;
  localparam int B_SRC_RDERR = 6;
  localparam int B_DST_RDERR = 7;
  localparam int B_DATA_RD   = 8;
  localparam int B_DATA_WR   = 9;
  localparam int B_DMA_DONE  = 10;
  localparam int B_PAUSE     = 11;

  // word map
  localparam int W_STATUS  = 0;
  localparam int W_MASK    = 1;
  localparam int W_ENABLE  = 2;
  localparam int W_DISABLE = 3;
  localparam int W_SRC_CNT = 4;
  localparam int W_DST_CNT = 5;
  localparam int W_LAST    = W_DST_CNT;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_MASK, SEL_SRC_CNT, SEL_DST_CNT
  } readSelT;

  typedef struct packed {
    logic    statusWr;
    logic    maskClr;
    logic    maskSet;
    logic    srcCntRd;
    logic    dstCntRd;
    logic    badAccess;
    readSelT rdSel;
  } ctrlStrobesT;
endpackage

// File: rtl/dmaIrqDecode.sv
module dmaIrqDecode
  import dmaIrqPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobesT       strobes
);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(W_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(W_MASK);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(W_ENABLE);
  localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(W_DISABLE);
  localparam logic [ADDR_W-1:0] A_SRC     = ADDR_W'(W_SRC_CNT);
  localparam logic [ADDR_W-1:0] A_DST     = ADDR_W'(W_DST_CNT);
  localparam logic [ADDR_W-1:0] A_LAST    = ADDR_W'(W_LAST);

  logic isRead;
  logic isWrite;

  assign isRead  = regEn && !regWe;
  assign isWrite = regEn && regWe;

  always_comb begin
    strobes           = '0;
    strobes.rdSel     = SEL_NONE;
    strobes.badAccess = regEn && (regAddr > A_LAST);
    if (isWrite) begin
      unique case (regAddr)
        A_STATUS:  strobes.statusWr = 1'b1;
        A_ENABLE:  strobes.maskClr  = 1'b1;
        A_DISABLE: strobes.maskSet  = 1'b1;
        default:   ;
      endcase
    end
    if (isRead) begin
      unique case (regAddr)
        A_STATUS: strobes.rdSel = SEL_STATUS;
        A_MASK:   strobes.rdSel = SEL_MASK;
        A_SRC: begin
          strobes.rdSel    = SEL_SRC_CNT;
          strobes.srcCntRd = 1'b1;
        end
        A_DST: begin
          strobes.rdSel    = SEL_DST_CNT;
          strobes.dstCntRd = 1'b1;
        end
        default: strobes.rdSel = SEL_NONE;
      endcase
    end
  end

  // R8: at most one side effect per access
  p_single_action_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.statusWr, strobes.maskClr, strobes.maskSet,
              strobes.srcCntRd, strobes.dstCntRd, strobes.badAccess}));

  // R11: no read path selected outside a read
  p_idle_no_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |-> strobes.rdSel == SEL_NONE);
endmodule

// File: rtl/dmaIrqAcct.sv
module dmaIrqAcct #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             rdClr,
  output logic [CNT_W-1:0] count,
  output logic             wrapped
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign wrapped = inc && !rdClr && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (rdClr) begin
      count <= inc ? CNT_ONE : '0;
    end else if (inc) begin
      count <= count + CNT_ONE;
    end
  end

  // R7 / R10: a read leaves at most the concurrent increment
  p_rdclr_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdClr |=> count <= CNT_ONE);

  // R6: the counter rolls over to zero from its maximum
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !rdClr && count == CNT_MAX) |=> count == '0);

  // R6: without an increment or read the count holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !rdClr) |=> $stable(count));
endmodule

// File: rtl/dmaIrqState.sv
module dmaIrqState
  import dmaIrqPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evSrcDscrDone,
  input  logic              evDstDscrDone,
  input  logic              evByteCntOvf,
  input  logic              evSrcDscrRdErr,
  input  logic              evDstDscrRdErr,
  input  logic              evDataRdErr,
  input  logic              evDataWrErr,
  input  logic              evDmaDone,
  input  logic              evDmaPause,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NUM_CNT = 2;
  localparam logic [NUM_SRC-1:0] MASK_RESET = '1;

  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] wbits;

  logic [NUM_CNT-1:0] cntInc;
  logic [NUM_CNT-1:0] cntRd;
  logic [NUM_CNT-1:0] cntWrap;
  logic [CNT_W-1:0]   cntVal [NUM_CNT];

  assign wbits  = wdata[NUM_SRC-1:0];
  assign cntInc = {evDstDscrDone, evSrcDscrDone};
  assign cntRd  = {strobes.dstCntRd, strobes.srcCntRd};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_acct
    dmaIrqAcct #(.CNT_W(CNT_W)) i_acct (
      .clk     (clk),
      .rstN    (rstN),
      .inc     (cntInc[g]),
      .rdClr   (cntRd[g]),
      .count   (cntVal[g]),
      .wrapped (cntWrap[g])
    );
  end

  always_comb begin
    setVec              = '0;
    setVec[B_BAD_ACC]   = strobes.badAccess;
    setVec[B_SRC_DONE]  = evSrcDscrDone;
    setVec[B_DST_DONE]  = evDstDscrDone;
    setVec[B_BYTE_OVF]  = evByteCntOvf;
    setVec[B_SRC_ACCT]  = cntWrap[0];
    setVec[B_DST_ACCT]  = cntWrap[1];
    setVec[B_SRC_RDERR] = evSrcDscrRdErr;
    setVec[B_DST_RDERR] = evDstDscrRdErr;
    setVec[B_DATA_RD]   = evDataRdErr;
    setVec[B_DATA_WR]   = evDataWrErr;
    setVec[B_DMA_DONE]  = evDmaDone;
    setVec[B_PAUSE]     = evDmaPause;
  end

  assign clrVec = strobes.statusWr ? wbits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      mask   <= MASK_RESET;
    end else begin
      status <= (status & ~clrVec) | setVec;
      if (strobes.maskClr) begin
        mask <= mask & ~wbits;
      end else if (strobes.maskSet) begin
        mask <= mask | wbits;
      end
    end
  end

  assign irq = |(status & ~mask);

  always_comb begin
    unique case (strobes.rdSel)
      SEL_STATUS:  rdata = DATA_W'(status);
      SEL_MASK:    rdata = DATA_W'(mask);
      SEL_SRC_CNT: rdata = DATA_W'(cntVal[0]);
      SEL_DST_CNT: rdata = DATA_W'(cntVal[1]);
      default:     rdata = '0;
    endcase
  end

  // R9: a hardware set beats a concurrent clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    evDmaDone |=> status[B_DMA_DONE]);

  // R1: pause event is recorded
  p_pause_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    evDmaPause |=> status[B_PAUSE]);

  // R3: mask moves only through enable/disable
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.maskClr || strobes.maskSet) |=> $stable(mask));

  // R8: invalid access flagged
  p_bad_access_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.badAccess |=> status[B_BAD_ACC]);

  // R6: counter wrap raises the accounting error bits
  p_src_acct_r6: assert property (@(posedge clk) disable iff (!rstN)
    cntWrap[0] |=> status[B_SRC_ACCT]);
  p_dst_acct_r6: assert property (@(posedge clk) disable iff (!rstN)
    cntWrap[1] |=> status[B_DST_ACCT]);

  // R2: untouched status bits stay set without a write
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.statusWr |=> (status & $past(status)) == $past(status));

  // R2: reserved bits of the read word are zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dmaIrqPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evSrcDscrDone,
  input  logic              evDstDscrDone,
  input  logic              evByteCntOvf,
  input  logic              evSrcDscrRdErr,
  input  logic              evDstDscrRdErr,
  input  logic              evDataRdErr,
  input  logic              evDataWrErr,
  input  logic              evDmaDone,
  input  logic              evDmaPause,
  output logic              irqOut
);
  ctrlStrobesT strobes;

  dmaIrqDecode #(.ADDR_W(ADDR_W)) i_decode (
    .clk     (clk),
    .rstN    (rstN),
    .regEn   (regEn),
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  dmaIrqState #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_state (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .wdata          (regWdata),
    .evSrcDscrDone  (evSrcDscrDone),
    .evDstDscrDone  (evDstDscrDone),
    .evByteCntOvf   (evByteCntOvf),
    .evSrcDscrRdErr (evSrcDscrRdErr),
    .evDstDscrRdErr (evDstDscrRdErr),
    .evDataRdErr    (evDataRdErr),
    .evDataWrErr    (evDataWrErr),
    .evDmaDone      (evDmaDone),
    .evDmaPause     (evDmaPause),
    .rdata          (regRdata),
    .irq            (irqOut)
  );

  // R11: nothing is driven on the read bus outside a read
  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(regEn && !regWe) |-> regRdata == '0);
endmodule

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [8:0]  ev = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [11:0] mStatus;
  logic [11:0] mMask;
  logic [7:0]  mSrc;
  logic [7:0]  mDst;

  always #10 clk = ~clk;

  dma_irq_ctrl i_dma_irq_ctrl (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .evSrcDscrDone(ev[0]), .evDstDscrDone(ev[1]), .evByteCntOvf(ev[2]),
    .evSrcDscrRdErr(ev[3]), .evDstDscrRdErr(ev[4]), .evDataRdErr(ev[5]),
    .evDataWrErr(ev[6]), .evDmaDone(ev[7]), .evDmaPause(ev[8]),
    .irqOut(irqOut)
  );

  // R1: map event pins to status bit positions
  function automatic logic [11:0] evToBits(logic [8:0] e);
    logic [11:0] b = '0;
    b[1] = e[0]; b[2] = e[1]; b[3] = e[2]; b[6] = e[3]; b[7] = e[4];
    b[8] = e[5]; b[9] = e[6]; b[10] = e[7]; b[11] = e[8];
    return b;
  endfunction

  function automatic logic [31:0] expRead(logic en, logic we, logic [3:0] a);
    if (!en || we) return '0;
    case (a)
      4'd0: return {20'd0, mStatus};
      4'd1: return {20'd0, mMask};
      4'd4: return {24'd0, mSrc};
      4'd5: return {24'd0, mDst};
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic [8:0] e, logic en, logic we, logic [3:0] a,
                           logic [31:0] wd);
    logic [11:0] setB = evToBits(e);
    logic [11:0] clrB = '0;
    logic srcRd = en && !we && a == 4'd4;
    logic dstRd = en && !we && a == 4'd5;
    if (e[0] && !srcRd && mSrc == 8'hFF) setB[4] = 1'b1;
    if (e[1] && !dstRd && mDst == 8'hFF) setB[5] = 1'b1;
    if (en && a > 4'd5) setB[0] = 1'b1;
    if (en && we && a == 4'd0) clrB = wd[11:0];
    mSrc = srcRd ? {7'd0, e[0]} : mSrc + {7'd0, e[0]};
    mDst = dstRd ? {7'd0, e[1]} : mDst + {7'd0, e[1]};
    mStatus = (mStatus & ~clrB) | setB;
    if (en && we && a == 4'd2) mMask = mMask & ~wd[11:0];
    if (en && we && a == 4'd3) mMask = mMask | wd[11:0];
  endtask

  // one clock cycle: check irq, drive inputs, check read data, advance model
  task automatic cyc(string tag, logic [8:0] e, logic en, logic we,
                     logic [3:0] a, logic [31:0] wd);
    @(negedge clk);
    check("R5 irq", {31'd0, irqOut}, {31'd0, |(mStatus & ~mMask)});
    ev = e; regEn = en; regWe = we; regAddr = a; regWdata = wd;
    #2;
    check(tag, regRdata, expRead(en, we, a));
    modelStep(e, en, we, a, wd);
  endtask

  task automatic rd(string tag, logic [3:0] a);
    cyc(tag, '0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic wr(string tag, logic [3:0] a, logic [31:0] wd);
    cyc(tag, '0, 1'b1, 1'b1, a, wd);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mStatus = '0; mMask = 12'hFFF; mSrc = '0; mDst = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd("R2 status reset", 4'd0);
    rd("R3 mask reset", 4'd1);
    rd("R7 src count reset", 4'd4);
    rd("R7 dst count reset", 4'd5);

    // R1: each event alone
    for (int i = 0; i < 9; i++) begin
      cyc("R1 event", 9'(1 << i), 1'b0, 1'b0, '0, '0);
      rd("R1 status bit", 4'd0);
      wr("R2 w1c", 4'd0, 32'hFFFF_FFFF);
      rd("R2 cleared", 4'd0);
    end

    // R2 partial clear, R11 idle read bus
    cyc("R10 multi event", 9'h1FF, 1'b0, 1'b0, '0, '0);
    wr("R2 partial", 4'd0, 32'h0000_0F0F);
    rd("R2 partial rd", 4'd0);
    cyc("R11 idle", '0, 1'b0, 1'b0, 4'd0, '0);

    // R9: set and clear same bit
    cyc("R9 collide", 9'h080, 1'b1, 1'b1, 4'd0, 32'h0000_0400);
    rd("R9 bit kept", 4'd0);

    // R3 / R4 / R5
    wr("R3 mask write", 4'd1, 32'h0);
    rd("R3 mask unchanged", 4'd1);
    wr("R4 enable", 4'd2, 32'h0000_0400);
    rd("R4 enable rd zero", 4'd2);
    rd("R4 mask after enable", 4'd1);
    wr("R4 disable", 4'd3, 32'h0000_0400);
    rd("R4 disable rd zero", 4'd3);
    rd("R4 mask after disable", 4'd1);
    wr("R4 enable all", 4'd2, 32'hFFFF_FFFF);
    wr("R2 clear all", 4'd0, 32'hFFF);
    rd("R5 none pending", 4'd0);

    // R7: writes ignored, read clears
    cyc("R7 inc", 9'h003, 1'b0, 1'b0, '0, '0);
    wr("R7 write src", 4'd4, 32'h55);
    wr("R7 write dst", 4'd5, 32'h55);
    rd("R7 read src", 4'd4);
    rd("R7 src cleared", 4'd4);
    rd("R7 read dst", 4'd5);
    rd("R7 dst cleared", 4'd5);

    // R10: read in same cycle as increment
    cyc("R10 inc", 9'h001, 1'b0, 1'b0, '0, '0);
    cyc("R10 read+inc", 9'h001, 1'b1, 1'b0, 4'd4, '0);
    rd("R10 count one", 4'd4);

    // R6: wrap of both counters
    for (int i = 0; i < 256; i++) cyc("R6 fill", 9'h003, 1'b0, 1'b0, '0, '0);
    rd("R6 acct bits", 4'd0);
    rd("R6 src wrapped", 4'd4);
    rd("R6 dst wrapped", 4'd5);
    wr("R2 clear", 4'd0, 32'hFFF);

    // R8: unmapped words
    wr("R8 write bad", 4'd9, 32'hFFFF_FFFF);
    rd("R8 bad flagged", 4'd0);
    rd("R8 read bad", 4'd15);
    rd("R8 mask untouched", 4'd1);

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      logic [8:0]  e  = 9'($urandom) & 9'($urandom);
      logic        en = ($urandom % 3) != 0;
      logic        we = $urandom % 2;
      logic [3:0]  a  = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 6);
      logic [31:0] wd = $urandom;
      if (a == 4'd4 || a == 4'd5) en = en && ($urandom % 8 == 0);
      cyc("R2 R3 R4 R7 R8 random", e, en, we, a, wd);
    end

    cyc("R5 final", '0, 1'b0, 1'b0, '0, '0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule